// File: doc/BRIEF.md
# Abstract Register-Access Command Sequencer

This block sits between a debug transport and a halted hart. A debugger writes a 32-bit abstract command word. When the word asks for a register access, the block writes a short stub of RISC-V machine code into a five-word abstract program RAM, one word per cycle. It then raises a one-cycle GO pulse that tells the hart to run the stub. The stub moves a value between the named register and a fixed data address, which is reached as a 12-bit immediate from x0. For CSRs the stub also saves and restores s0 through the debug scratch CSR.

The block also holds the data words and the program buffer, and it guards both while a command is in flight. It keeps a sticky error code and supports auto-execution, which re-runs the last command when a selected data or buffer word is touched. A hart-side fetch port shows the abstract RAM, then the program buffer, then one word that is always ebreak. The busy flag drops when external handshake logic signals that the hart has finished.

Top module: `abs_cmd_seq`

## Requirements
- R1: A command is a register access only when its bits 31:24 are zero. Any other value sets the error code to 2 (not supported). Error codes are: 0 none, 1 busy, 2 not supported, 4 hart not halted. The other command fields are: bits 22:20 size, bit 18 post-execute, bit 17 transfer, bit 16 write, bits 15:0 register number.
- R2: While the error code is nonzero, a new command is ignored and changes neither busy nor the error code. Writing a clear mask clears only the error bits set in the mask.
- R3: A command issued while busy sets the error code to 1.
- R4: A command to a hart that is not halted sets the error code to 4. It writes no stub word and leaves busy low.
- R5: Register numbers 0x1000 to 0x101F select x0 to x31, and 0x1020 to 0x103F select f0 to f31. A write generates a load (lw/ld or flw/fld) into the register from DATA_ADDR(x0). A read generates a store (sw/sd or fsw/fsd) from the register to DATA_ADDR(x0).
- R6: Numbers below 0x1000 are CSRs and are accepted only when PBUF_WORDS is below 2. The stub is four words: csrrw x0,0x7B2,s0; then the move through s0 (a load then a CSR write for a write, a CSR read then a store for a read); then csrrs s0,0x7B2,x0. Any other register number sets error 2.
- R7: Size 2 selects 32-bit accesses and size 3 selects 64-bit accesses. Any other size with transfer set gives error 2.
- R8: The last stub word is ebreak (0x00100073). With post-execute set, it is instead a jal x0 whose offset is 4*(5-i), where i is that word's index, so that it reaches the program-buffer start. With transfer clear, this last word is the only word and sits at index 0.
- R9: After reset, busy, error and GO are zero. An accepted command raises busy at its own clock edge. Stub word k is written at edge k+1 after acceptance. GO is a single-cycle pulse seen after edge n, where n is the word count. Busy falls at the first handshake strobe after GO.
- R10: When not busy, a data access or buffer access whose index bit is set in the matching auto-execute mask re-runs the last command written. An access whose bit is clear does not.
- R11: While busy, data and buffer reads return 0xFFFFFFFF and writes are dropped. A data access while busy sets error 1 if the error code is 0. A buffer access while busy leaves the error code unchanged.
- R12: The hart fetch window maps addresses 0 to 4 to the abstract RAM and 5 to 5+PBUF_WORDS-1 to the program buffer. The address right after the buffer always reads ebreak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write and run a command word |
| cmd_wdata | input | 32 | Command word |
| errclr_wr | input | 1 | Apply write-1-to-clear mask to error code |
| errclr_mask | input | 3 | Error bits to clear |
| auto_wr | input | 1 | Load auto-execute masks |
| auto_data_mask | input | DATA_WORDS | Data indices that trigger re-run |
| auto_pbuf_mask | input | PBUF_WORDS | Buffer indices that trigger re-run |
| hart_halted | input | 1 | Selected hart is halted |
| handshake_done | input | 1 | Hart finished the stub; clears busy |
| acc_en | input | 1 | Debugger access strobe |
| acc_pbuf | input | 1 | 1 selects program buffer, 0 selects data |
| acc_we | input | 1 | Access is a write |
| acc_idx | input | IDX_W | Word index of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, registered |
| hart_addr | input | HART_W | Hart fetch word address |
| hart_rdata | output | 32 | Hart fetch data, registered |
| busy | output | 1 | Command in flight |
| cmderr | output | 3 | Sticky error code |
| go_set | output | 1 | One-cycle GO pulse after the last stub word |

## Verification
The bench builds the block with two data words and a one-word program buffer. The small buffer keeps the four-word CSR stub legal, so all three register classes and both stub endings can be checked word by word through the fetch port. The fetch window is only seven words, so the fixed ebreak after the buffer is reached directly at address 6. Rejection of CSRs when the buffer holds two or more words is not reachable in this build.

// File: rtl/abs_seq_pkg.sv
package abs_seq_pkg;

  localparam int ABS_WORDS = 5;
  localparam int ABS_IW    = 3;

  localparam logic [2:0] ERR_NONE   = 3'd0;
  localparam logic [2:0] ERR_BUSY   = 3'd1;
  localparam logic [2:0] ERR_NOTSUP = 3'd2;
  localparam logic [2:0] ERR_HALT   = 3'd4;

  localparam logic [11:0] SCRATCH_CSR = 12'h7B2;
  localparam logic [4:0]  REG_S0      = 5'd8;
  localparam logic [31:0] EBREAK_W    = 32'h0010_0073;

  typedef enum logic [1:0] {XK_NONE, XK_CSR, XK_GPR, XK_FPR} xfer_kind_e;

  typedef struct packed {
    xfer_kind_e  kind;
    logic        wr;
    logic        dbl;
    logic        post;
    logic [11:0] regsel;
    logic [2:0]  nwords;
  } seq_plan_t;

  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  // half = byte offset / 2
  function automatic logic [31:0] enc_jal(input logic [19:0] half);
    return {half[19], half[9:0], half[10], half[18:11], 5'd0, 7'h6F};
  endfunction

endpackage

// File: rtl/abs_cmd_decode.sv
module abs_cmd_decode
  import abs_seq_pkg::*;
#(
  parameter int PBUF_WORDS = 1
) (
  input  logic [31:0] cmd,
  input  logic        halted,
  output seq_plan_t   plan,
  output logic [2:0]  err
);

  localparam bit CSR_OK = (PBUF_WORDS < 2);

  logic [2:0]  size;
  logic [15:0] regno;
  logic        unused_bits;

  assign size        = cmd[22:20];
  assign regno       = cmd[15:0];
  assign unused_bits = ^{cmd[23], cmd[19]};

  always_comb begin
    plan        = '0;
    err         = ERR_NONE;
    plan.wr     = cmd[16];
    plan.dbl    = (size == 3'd3);
    plan.post   = cmd[18];
    plan.regsel = regno[11:0];
    plan.kind   = XK_NONE;
    if (cmd[31:24] != 8'd0) begin
      err = ERR_NOTSUP;
    end else if (!halted) begin
      err = ERR_HALT;
    end else if (cmd[17]) begin
      if (CSR_OK && regno < 16'h1000)       plan.kind = XK_CSR;
      else if (regno[15:5] == 11'h080)      plan.kind = XK_GPR;
      else if (regno[15:5] == 11'h081)      plan.kind = XK_FPR;
      else                                  err = ERR_NOTSUP;
      if (err == ERR_NONE && size != 3'd2 && size != 3'd3) err = ERR_NOTSUP;
    end
    case (plan.kind)
      XK_CSR:  plan.nwords = 3'd5;
      XK_GPR,
      XK_FPR:  plan.nwords = 3'd2;
      default: plan.nwords = 3'd1;
    endcase
  end

endmodule

// File: rtl/abs_word_gen.sv
module abs_word_gen
  import abs_seq_pkg::*;
#(
  parameter logic [11:0] DATA_ADDR = 12'h380
) (
  input  seq_plan_t   plan,
  input  logic [2:0]  step,
  output logic [31:0] word
);

  logic [2:0]  f3;
  logic [4:0]  rn;
  logic [31:0] ld_w, st_w, ld_s0, st_s0;

  assign f3    = plan.dbl ? 3'b011 : 3'b010;
  assign rn    = plan.regsel[4:0];
  assign ld_w  = enc_i(DATA_ADDR, 5'd0, f3, rn, (plan.kind == XK_FPR) ? 7'h07 : 7'h03);
  assign st_w  = enc_s(DATA_ADDR, rn, 5'd0, f3, (plan.kind == XK_FPR) ? 7'h27 : 7'h23);
  assign ld_s0 = enc_i(DATA_ADDR, 5'd0, f3, REG_S0, 7'h03);
  assign st_s0 = enc_s(DATA_ADDR, REG_S0, 5'd0, f3, 7'h23);

  always_comb begin
    word = EBREAK_W;
    if (step == plan.nwords - 3'd1) begin
      if (plan.post) word = enc_jal(20'((ABS_WORDS - int'(step)) * 2));
    end else begin
      case (plan.kind)
        XK_GPR, XK_FPR: word = plan.wr ? ld_w : st_w;
        XK_CSR: begin
          case (step)
            3'd0:    word = enc_i(SCRATCH_CSR, REG_S0, 3'b001, 5'd0, 7'h73);
            3'd1:    word = plan.wr ? ld_s0 : enc_i(plan.regsel, 5'd0, 3'b010, REG_S0, 7'h73);
            3'd2:    word = plan.wr ? enc_i(plan.regsel, REG_S0, 3'b001, 5'd0, 7'h73) : st_s0;
            default: word = enc_i(SCRATCH_CSR, 5'd0, 3'b010, REG_S0, 7'h73);
          endcase
        end
        default: word = EBREAK_W;
      endcase
    end
  end

endmodule

// File: rtl/abs_cmd_seq.sv
module abs_cmd_seq
  import abs_seq_pkg::*;
#(
  parameter int          DATA_WORDS = 2,
  parameter int          PBUF_WORDS = 1,
  parameter logic [11:0] DATA_ADDR  = 12'h380,
  localparam int ACC_DEPTH = (DATA_WORDS > PBUF_WORDS) ? DATA_WORDS : PBUF_WORDS,
  localparam int IDX_W     = (ACC_DEPTH > 1) ? $clog2(ACC_DEPTH) : 1,
  localparam int HART_W    = $clog2(ABS_WORDS + PBUF_WORDS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_wr,
  input  logic [31:0]           cmd_wdata,
  input  logic                  errclr_wr,
  input  logic [2:0]            errclr_mask,
  input  logic                  auto_wr,
  input  logic [DATA_WORDS-1:0] auto_data_mask,
  input  logic [PBUF_WORDS-1:0] auto_pbuf_mask,
  input  logic                  hart_halted,
  input  logic                  handshake_done,
  input  logic                  acc_en,
  input  logic                  acc_pbuf,
  input  logic                  acc_we,
  input  logic [IDX_W-1:0]      acc_idx,
  input  logic [31:0]           acc_wdata,
  output logic [31:0]           acc_rdata,
  input  logic [HART_W-1:0]     hart_addr,
  output logic [31:0]           hart_rdata,
  output logic                  busy,
  output logic [2:0]            cmderr,
  output logic                  go_set
);

  logic [31:0] data_mem [ACC_DEPTH];
  logic [31:0] pbuf_mem [ACC_DEPTH];
  logic [31:0] abs_mem  [ABS_WORDS];

  logic [ACC_DEPTH-1:0] auto_data_q, auto_pb_q;
  logic [31:0]          cmd_q;
  seq_plan_t            plan_q, dec_plan;
  logic [2:0]           dec_err, err_n;
  logic                 seq_active;
  logic [2:0]           step;
  logic [31:0]          gen_word;

  logic hit_data, hit_pb, auto_fire, run_req;
  logic [31:0] run_word;
  logic [IDX_W-1:0] pb_off;

  assign hit_data  = acc_en && !acc_pbuf && (int'(acc_idx) < DATA_WORDS);
  assign hit_pb    = acc_en &&  acc_pbuf && (int'(acc_idx) < PBUF_WORDS);
  assign auto_fire = !busy && ((hit_data && auto_data_q[acc_idx]) || (hit_pb && auto_pb_q[acc_idx]));
  assign run_req   = cmd_wr || auto_fire;
  assign run_word  = cmd_wr ? cmd_wdata : cmd_q;
  assign pb_off    = IDX_W'(hart_addr - HART_W'(ABS_WORDS));

  abs_cmd_decode #(.PBUF_WORDS(PBUF_WORDS)) dec_i (
    .cmd(run_word), .halted(hart_halted), .plan(dec_plan), .err(dec_err)
  );

  abs_word_gen #(.DATA_ADDR(DATA_ADDR)) gen_i (
    .plan(plan_q), .step(step), .word(gen_word)
  );

  always_comb begin
    err_n = cmderr;
    if (errclr_wr) err_n = cmderr & ~errclr_mask;
    if (hit_data && busy && cmderr == ERR_NONE) err_n = ERR_BUSY;
    if (run_req && cmderr == ERR_NONE) begin
      if (busy)                     err_n = ERR_BUSY;
      else if (dec_err != ERR_NONE) err_n = dec_err;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      cmderr      <= ERR_NONE;
      seq_active  <= 1'b0;
      step        <= '0;
      plan_q      <= '0;
      go_set      <= 1'b0;
      cmd_q       <= '0;
      auto_data_q <= '0;
      auto_pb_q   <= '0;
    end else begin
      go_set <= 1'b0;
      cmderr <= err_n;
      if (auto_wr) begin
        auto_data_q <= ACC_DEPTH'(auto_data_mask);
        auto_pb_q   <= ACC_DEPTH'(auto_pbuf_mask);
      end
      if (cmd_wr) cmd_q <= cmd_wdata;
      if (run_req && cmderr == ERR_NONE && !busy && dec_err == ERR_NONE) begin
        busy       <= 1'b1;
        seq_active <= 1'b1;
        step       <= '0;
        plan_q     <= dec_plan;
      end
      if (seq_active) begin
        step <= step + 3'd1;
        if (step == plan_q.nwords - 3'd1) begin
          seq_active <= 1'b0;
          go_set     <= 1'b1;
        end
      end
      if (busy && !seq_active && !go_set && handshake_done) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (seq_active) abs_mem[step] <= gen_word;
  end

  always_ff @(posedge clk) begin
    if (hit_data && acc_we && !busy) data_mem[acc_idx] <= acc_wdata;
  end

  always_ff @(posedge clk) begin
    if (hit_pb && acc_we && !busy) pbuf_mem[acc_idx] <= acc_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata <= '0;
    end else if (acc_en && !acc_we) begin
      if (busy)          acc_rdata <= '1;
      else if (acc_pbuf) acc_rdata <= pbuf_mem[acc_idx];
      else               acc_rdata <= data_mem[acc_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (int'(hart_addr) < ABS_WORDS)                   hart_rdata <= abs_mem[ABS_IW'(hart_addr)];
    else if (int'(hart_addr) < ABS_WORDS + PBUF_WORDS) hart_rdata <= pbuf_mem[pb_off];
    else if (int'(hart_addr) == ABS_WORDS + PBUF_WORDS) hart_rdata <= EBREAK_W;
    else                                               hart_rdata <= '0;
  end

endmodule

// File: rtl/abs_cmd_seq_chk.sv
module abs_cmd_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        go_set,
  input logic [2:0]  cmderr,
  input logic        errclr_wr,
  input logic        hart_halted,
  input logic        acc_en,
  input logic        acc_we,
  input logic [31:0] acc_rdata
);

  // R9
  go_busy_chk: assert property (@(posedge clk) disable iff (rst) go_set |-> busy);

  // R9
  go_pulse_chk: assert property (@(posedge clk) disable iff (rst) go_set |=> !go_set);

  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (cmderr != 3'd0 && !errclr_wr) |=> cmderr == $past(cmderr));

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(hart_halted) && $past(cmderr) == 3'd0));

  // R11
  busy_read_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_we && busy) |=> acc_rdata == 32'hFFFF_FFFF);

endmodule

bind abs_cmd_seq abs_cmd_seq_chk chk_i (
  .clk(clk), .rst(rst), .busy(busy), .go_set(go_set), .cmderr(cmderr),
  .errclr_wr(errclr_wr), .hart_halted(hart_halted), .acc_en(acc_en),
  .acc_we(acc_we), .acc_rdata(acc_rdata)
);

// File: tb/abs_cmd_seq_tb.sv
module abs_cmd_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EBRK = 32'h0010_0073;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 0, errclr_wr = 0, auto_wr = 0, handshake_done = 0;
  logic [31:0] cmd_wdata = 0, acc_wdata = 0;
  logic [2:0]  errclr_mask = 0;
  logic [1:0]  auto_data_mask = 0;
  logic [0:0]  auto_pbuf_mask = 0;
  logic        hart_halted = 1;
  logic        acc_en = 0, acc_pbuf = 0, acc_we = 0;
  logic [0:0]  acc_idx = 0;
  logic [31:0] acc_rdata, hart_rdata;
  logic [2:0]  hart_addr = 0;
  logic        busy, go_set;
  logic [2:0]  cmderr;

  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  abs_cmd_seq #(.DATA_WORDS(2), .PBUF_WORDS(1), .DATA_ADDR(12'h380)) dut_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .errclr_wr(errclr_wr), .errclr_mask(errclr_mask), .auto_wr(auto_wr),
    .auto_data_mask(auto_data_mask), .auto_pbuf_mask(auto_pbuf_mask),
    .hart_halted(hart_halted), .handshake_done(handshake_done),
    .acc_en(acc_en), .acc_pbuf(acc_pbuf), .acc_we(acc_we), .acc_idx(acc_idx),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .hart_addr(hart_addr),
    .hart_rdata(hart_rdata), .busy(busy), .cmderr(cmderr), .go_set(go_set)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w);
    cmd_wr = 1; cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 0;
  endtask

  task automatic wait_go(input string req, input int n);
    int got = 0;
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      if (go_set && got == 0) got = c;
    end
    check(req, got, n);
  endtask

  task automatic release_busy(input string req);
    handshake_done = 1;
    @(negedge clk);
    handshake_done = 0;
    check(req, {31'd0, busy}, 32'd0);
  endtask

  task automatic clear_err(input logic [2:0] m);
    errclr_wr = 1; errclr_mask = m;
    @(negedge clk);
    errclr_wr = 0;
  endtask

  task automatic hart_rd(input logic [2:0] a, output logic [31:0] d);
    hart_addr = a;
    @(negedge clk);
    d = hart_rdata;
  endtask

  task automatic acc(input logic pb, input logic we, input logic i,
                     input logic [31:0] wd, output logic [31:0] rd);
    acc_en = 1; acc_pbuf = pb; acc_we = we; acc_idx = i; acc_wdata = wd;
    @(negedge clk);
    acc_en = 0; acc_we = 0;
    rd = acc_rdata;
  endtask

  task automatic t_reset();
    check("R9 reset busy", {31'd0, busy}, 0);
    check("R9 reset cmderr", {29'd0, cmderr}, 0);
    check("R9 reset go", {31'd0, go_set}, 0);
  endtask

  task automatic t_gpr();
    logic [31:0] d;
    issue(32'h0023_100A);
    check("R9 busy on accept", {31'd0, busy}, 1);
    wait_go("R9 go after 2 words", 2);
    hart_rd(3'd0, d); check("R5 lw x10", d, 32'h3800_2503);
    hart_rd(3'd1, d); check("R8 ebreak end", d, EBRK);
    release_busy("R9 busy cleared");
  endtask

  task automatic t_fpr_post();
    logic [31:0] d;
    issue(32'h0036_1023);
    wait_go("R9 go fpr", 2);
    hart_rd(3'd0, d); check("R5 fsd f3", d, 32'h3830_3027);
    hart_rd(3'd1, d); check("R8 jal to buffer", d, 32'h0100_006F);
    release_busy("R9 busy cleared fpr");
  endtask

  task automatic t_csr();
    logic [31:0] d;
    issue(32'h0022_0300);
    wait_go("R6 go after 5 words", 5);
    hart_rd(3'd0, d); check("R6 save s0", d, 32'h7B24_1073);
    hart_rd(3'd1, d); check("R6 csr read", d, 32'h3000_2473);
    hart_rd(3'd2, d); check("R6 store s0", d, 32'h3880_2023);
    hart_rd(3'd3, d); check("R6 restore s0", d, 32'h7B20_2473);
    hart_rd(3'd4, d); check("R8 csr ebreak", d, EBRK);
    release_busy("R9 busy cleared csr");
  endtask

  task automatic t_noxfer();
    logic [31:0] d;
    issue(32'h0004_0000);
    wait_go("R8 single word", 1);
    hart_rd(3'd0, d); check("R8 jal at index 0", d, 32'h0140_006F);
    release_busy("R9 busy cleared noxfer");
  endtask

  task automatic t_errors();
    logic [31:0] d;
    issue(32'h0100_0000);
    check("R1 type error", {29'd0, cmderr}, 2);
    check("R1 no busy", {31'd0, busy}, 0);
    issue(32'h0023_100A);
    check("R2 blocked busy", {31'd0, busy}, 0);
    check("R2 blocked err", {29'd0, cmderr}, 2);
    clear_err(3'd1);
    check("R2 partial clear", {29'd0, cmderr}, 2);
    clear_err(3'd2);
    check("R2 cleared", {29'd0, cmderr}, 0);
    issue(32'h0042_100A);
    check("R7 size 4", {29'd0, cmderr}, 2);
    clear_err(3'd7);
    issue(32'h0022_1040);
    check("R6 bad regno", {29'd0, cmderr}, 2);
    clear_err(3'd7);
    hart_halted = 0;
    issue(32'h0023_100A);
    check("R4 not halted err", {29'd0, cmderr}, 4);
    check("R4 not halted busy", {31'd0, busy}, 0);
    repeat (6) @(negedge clk);
    hart_rd(3'd0, d); check("R4 no word written", d, 32'h0140_006F);
    hart_halted = 1;
    clear_err(3'd7);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    acc(1'b0, 1'b1, 1'b0, 32'hA5A5_0001, d);
    acc(1'b0, 1'b1, 1'b1, 32'h0000_5555, d);
    issue(32'h0023_100A);
    acc(1'b1, 1'b0, 1'b0, 32'd0, d);
    check("R11 pbuf read ones", d, 32'hFFFF_FFFF);
    check("R11 pbuf no err", {29'd0, cmderr}, 0);
    acc(1'b0, 1'b0, 1'b0, 32'd0, d);
    check("R11 data read ones", d, 32'hFFFF_FFFF);
    check("R11 data busy err", {29'd0, cmderr}, 1);
    clear_err(3'd7);
    acc(1'b0, 1'b1, 1'b1, 32'hDEAD_BEEF, d);
    clear_err(3'd7);
    issue(32'h0023_100A);
    check("R3 cmd while busy", {29'd0, cmderr}, 1);
    clear_err(3'd7);
    repeat (4) @(negedge clk);
    release_busy("R9 busy cleared busy test");
    acc(1'b0, 1'b0, 1'b0, 32'd0, d);
    check("R11 data0 kept", d, 32'hA5A5_0001);
    acc(1'b0, 1'b0, 1'b1, 32'd0, d);
    check("R11 dropped write", d, 32'h0000_5555);
  endtask

  task automatic t_auto();
    logic [31:0] d;
    acc(1'b1, 1'b1, 1'b0, 32'h0000_0013, d);
    hart_rd(3'd5, d); check("R12 buffer word", d, 32'h0000_0013);
    hart_rd(3'd6, d); check("R12 trailing ebreak", d, EBRK);
    auto_wr = 1; auto_data_mask = 2'b01; auto_pbuf_mask = 1'b0;
    @(negedge clk); auto_wr = 0;
    acc(1'b0, 1'b1, 1'b0, 32'h1, d);
    check("R10 data auto fire", {31'd0, busy}, 1);
    wait_go("R10 auto go", 2);
    release_busy("R10 auto release");
    auto_wr = 1; auto_data_mask = 2'b00; auto_pbuf_mask = 1'b1;
    @(negedge clk); auto_wr = 0;
    acc(1'b0, 1'b0, 1'b0, 32'd0, d);
    check("R10 masked no fire", {31'd0, busy}, 0);
    acc(1'b1, 1'b0, 1'b0, 32'd0, d);
    check("R10 pbuf auto fire", {31'd0, busy}, 1);
    repeat (4) @(negedge clk);
    release_busy("R10 pbuf release");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_gpr();
    t_fpr_post();
    t_csr();
    t_noxfer();
    t_errors();
    t_busy();
    t_auto();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule